// File: doc/BRIEF.md
# Multicart Reset-Stepped Game Selector

This block sits between a banked cartridge mapper and the memories of a three-game multicart. It holds a game index and, for each game, either forces or passes through the two top program-ROM address bits and the two top work-RAM address bits. Each game therefore sees its own program size and its own private slice of one shared battery-backed RAM. The three games are laid out as follows: one with 256 KB of program and 16 KB of RAM, one with 256 KB of program and 8 KB of RAM, and one with 512 KB of program and 8 KB of RAM.

A reset-event input advances the index by one for each console reset. The supply-drop sensing is outside the block and arrives here as a clean pulse. That input is synchronized and edge-detected. The index sits in logic that keeps its value across console resets. Only the asynchronous power-on clear returns it to the first game.

Top module: `multicart_game_sel`

## Requirements
- R1: While `rst_ni` is low, and after it rises with no event seen, the index is game 0.
- R2: In game 0, `prg_a19_o`=0, `prg_a18_o`=0 and `ram_a14_o`=0, and `ram_a13_o` follows `map_ram_a13_i`.
- R3: In game 1, `prg_a19_o`=0, `prg_a18_o`=1, `ram_a14_o`=1 and `ram_a13_o`=0, whatever the mapper inputs are.
- R4: In game 2, `prg_a19_o`=1, `prg_a18_o` follows `map_prg_a18_i`, and `ram_a14_o`=1 and `ram_a13_o`=1.
- R5: A rising edge on `reset_evt_i` advances the index by exactly one, however many cycles the input then stays high. The output bits reflect the new game no later than SYNC_STAGES+2 clock cycles after the edge.
- R6: An event taken in game 2 returns the index to game 0.
- R7: With `reset_evt_i` low, the index holds its value regardless of mapper-input activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock of the selector |
| rst_ni | input | 1 | Asynchronous active-low power-on clear |
| reset_evt_i | input | 1 | Supply-drop reset event, asynchronous, active high |
| map_prg_a18_i | input | 1 | Program A18 from the mapper |
| map_ram_a13_i | input | 1 | RAM A13 from the mapper |
| prg_a19_o | output | 1 | Final program-ROM A19 |
| prg_a18_o | output | 1 | Final program-ROM A18 |
| ram_a14_o | output | 1 | Final work-RAM A14 |
| ram_a13_o | output | 1 | Final work-RAM A13 |

## Verification
The bench drives every mapper-input combination in each game, which catches a table that forces a bit it should pass through, or the reverse. Such a fault would give one game a wrong ROM size or let two games overlap in RAM. The bench holds an event high for many cycles, and a design that counts levels instead of edges would skip games. It steps the index past game 2, and a counter without a wrap would reach an illegal fourth index. It also toggles the mapper inputs with no event present, which exposes any index change that is not caused by an event.

// File: rtl/game_sel_pkg.sv
package game_sel_pkg;
  localparam int unsigned NUM_GAMES = 3;
  localparam int unsigned GAME_W    = $clog2(NUM_GAMES);

  // bit order: [3]=prg a19, [2]=prg a18, [1]=ram a14, [0]=ram a13
  typedef struct packed {
    logic [3:0] force_m;
    logic [3:0] force_v;
  } pin_rule_t;

  function automatic pin_rule_t rule_of(input logic [GAME_W-1:0] g);
    pin_rule_t r;
    case (g)
      2'd1:    begin r.force_m = 4'b1111; r.force_v = 4'b0110; end
      2'd2:    begin r.force_m = 4'b1011; r.force_v = 4'b1011; end
      default: begin r.force_m = 4'b1110; r.force_v = 4'b0000; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/game_sel_evt_sync.sv
module game_sel_evt_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic step_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], evt_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign step_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R5: a single edge yields a single-cycle step
  a_r5_step_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);
endmodule

// File: rtl/game_sel_index.sv
module game_sel_index
  import game_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [GAME_W-1:0] game_o
);
  localparam logic [GAME_W-1:0] LAST = GAME_W'(NUM_GAMES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     game_o <= '0;
    else if (step_i) game_o <= (game_o == LAST) ? '0 : game_o + GAME_W'(1);
  end

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(game_o));
  a_r5_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && game_o != LAST) |=> game_o == $past(game_o) + GAME_W'(1));
  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && game_o == LAST) |=> game_o == '0);
  a_r6_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    game_o <= LAST);
endmodule

// File: rtl/game_sel_addr_map.sv
module game_sel_addr_map
  import game_sel_pkg::*;
(
  input  logic [GAME_W-1:0] game_i,
  input  logic [3:0]        map_i,
  output logic [3:0]        addr_o
);
  pin_rule_t rule;
  assign rule = rule_of(game_i);

  for (genvar i = 0; i < 4; i++) begin : g_bit
    assign addr_o[i] = rule.force_m[i] ? rule.force_v[i] : map_i[i];
  end
endmodule

// File: rtl/multicart_game_sel.sv
module multicart_game_sel
  import game_sel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reset_evt_i,
  input  logic map_prg_a18_i,
  input  logic map_ram_a13_i,
  output logic prg_a19_o,
  output logic prg_a18_o,
  output logic ram_a14_o,
  output logic ram_a13_o
);
  logic              step;
  logic [GAME_W-1:0] game;
  logic [3:0]        addr;

  game_sel_evt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(reset_evt_i), .step_o(step));

  game_sel_index u_index (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .game_o(game));

  game_sel_addr_map u_map (
    .game_i(game),
    .map_i ({1'b0, map_prg_a18_i, 1'b0, map_ram_a13_i}),
    .addr_o(addr));

  assign {prg_a19_o, prg_a18_o, ram_a14_o, ram_a13_o} = addr;

  a_r2_game0_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    game == 2'd0 |-> (!prg_a19_o && !prg_a18_o && !ram_a14_o && ram_a13_o == map_ram_a13_i));
  a_r3_game1_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    game == 2'd1 |-> ({prg_a19_o, prg_a18_o, ram_a14_o, ram_a13_o} == 4'b0110));
  a_r4_game2_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    game == 2'd2 |-> (prg_a19_o && prg_a18_o == map_prg_a18_i && ram_a14_o && ram_a13_o));
endmodule

// File: tb/multicart_game_sel_bench.sv
module multicart_game_sel_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0] exp;
    string      req;
  } item_t;

  logic clk = 0, rst_n = 0, evt = 0, m18 = 0, m13 = 0;
  logic a19, a18, a14, a13;
  item_t q[$];
  int checks = 0, fails = 0, model_game = 0;
  event sample_ev;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  multicart_game_sel u_multicart_game_sel (
    .clk_i(clk), .rst_ni(rst_n), .reset_evt_i(evt),
    .map_prg_a18_i(m18), .map_ram_a13_i(m13),
    .prg_a19_o(a19), .prg_a18_o(a18), .ram_a14_o(a14), .ram_a13_o(a13));

  function automatic logic [3:0] expect_of(int g, logic i18, logic i13);
    case (g)
      0: return {1'b0, 1'b0, 1'b0, i13};
      1: return 4'b0110;
      default: return {1'b1, i18, 1'b1, 1'b1};
    endcase
  endfunction

  task automatic drive(logic i18, logic i13, string req);
    item_t it;
    @(negedge clk);
    m18 = i18; m13 = i13;
    it.exp = expect_of(model_game, i18, i13);
    it.req = req;
    q.push_back(it);
    #(CLK_PERIOD/4);
    -> sample_ev;
    #1;
  endtask

  task automatic sweep(string req);
    for (int k = 0; k < 4; k++) drive(k[1], k[0], req);
  endtask

  task automatic fire(int hold);
    @(negedge clk); evt = 1;
    repeat (hold) @(negedge clk);
    evt = 0;
    repeat (6) @(negedge clk);
    model_game = (model_game + 1) % 3;
  endtask

  always begin
    @(sample_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [3:0] got;
      it = q.pop_front();
      got = {a19, a18, a14, a13};
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s game=%0d got=%b exp=%b", it.req, model_game, got, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    sweep("R1");                 // during clear
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    sweep("R2");
    fire(1);
    sweep("R3");
    for (int k = 0; k < 8; k++) drive(k[0], k[1], "R7"); // activity, no event
    fire(20);                    // long hold counts once
    sweep("R5_R4");
    fire(3);
    sweep("R6");
    fire(2); fire(2);
    sweep("R4");
    @(negedge clk); rst_n = 0; model_game = 0;
    sweep("R1");
    @(negedge clk); rst_n = 1;
    repeat (10) @(negedge clk);
    sweep("R7");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule